// File: doc/BRIEF.md
# Serial Byte-Order Load/Store Sequencer

This block sits between a processor's load/store path and a byte-wide memory port. One request moves a 8-, 16- or 32-bit value through the 8-bit port, one byte per clock, at consecutive addresses starting from the request's base address. A load builds the register word from the returned bytes. A store splits the register word into bytes. An order input picks which register byte lane each memory address belongs to. Three orders are supported: most-significant byte first, least-significant byte first, and a split-word order. In the split-word order the two 16-bit halves go high half first, but inside each half the low byte comes first.

The sequencer is a four-state machine. IDLE waits for a start strobe and latches the request (IDLE to XFER). XFER presents one address per clock and counts the beats. On the last beat it moves to FINISH for a store, or to TAIL for a load. TAIL exists only for loads: it waits one clock so the final read byte, which arrives a clock late, can be captured (TAIL to FINISH). FINISH raises the done pulse for one clock and returns to IDLE. Loads narrower than a word come back zero-extended in the low bits.

Top module: `byte_order_lsu`

## Requirements
- R1: While reset is held and just after it is released, done, mem_re and mem_we are low and rdata is zero.
- R2: With order code 0 (high byte first), a word access maps address A to rdata/wdata bits [31:24], A+1 to [23:16], A+2 to [15:8] and A+3 to [7:0].
- R3: With order code 1 (low byte first), a word access maps A to bits [7:0] and A+3 to bits [31:24], with the middle addresses in rising order. Reading back big-endian bytes of 0x12345678 this way gives 0x78563412.
- R4: With order code 2 (split word), storing 0x12345678 puts 0x34, 0x12, 0x78, 0x56 at A..A+3, and loading those bytes gives 0x12345678 back.
- R5: Size code 0 moves 1 byte, code 1 moves 2 bytes and code 2 moves 4 bytes. Each byte takes one clock. The addresses run A, A+1, and so on, on consecutive clocks, and no byte beyond A+n-1 is written.
- R6: For a 16-bit access, order 0 maps A to bits [15:8] and A+1 to bits [7:0]. Orders 1 and 2 both map A to bits [7:0] and A+1 to bits [15:8].
- R7: Byte and halfword loads return zero in every rdata bit above the bytes loaded.
- R8: Take the rising edge that accepts start as edge 0. Done is high for exactly one clock: after edge n for an n-byte store, and after edge n+1 for an n-byte load. rdata holds the loaded value from that clock onward.
- R9: A start strobe that arrives while a request is in progress (from the accepting edge through the done clock) causes no bus activity, neither then nor afterwards.
- R10: mem_re and mem_we are never high together, and neither is high in the clock where done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, taken only when idle |
| wr | input | 1 | 1 = store, 0 = load |
| base_addr | input | AW | Address of the first byte |
| size | input | 2 | 0 = byte, 1 = halfword, 2 = word |
| order | input | 2 | 0 = high first, 1 = low first, 2 = split word |
| wdata | input | DATA_W | Register value to store |
| rdata | output | DATA_W | Assembled load value |
| done | output | 1 | One-clock completion pulse |
| mem_addr | output | AW | Byte address to memory |
| mem_re | output | 1 | Read enable; data returns one clock later |
| mem_we | output | 1 | Write enable for the current byte |
| mem_wdata | output | 8 | Store byte for the current address |
| mem_rdata | input | 8 | Read byte from memory |

## Verification
A wrong beat count or a stuck step counter shows up on the bus right away. The address stops stepping, the sequence runs long or short, or done arrives off the expected clock, and all of these are visible within the same request. A wrong lane choice has no timing signature. It shows only as a misplaced byte in memory after a store, or in rdata on the done clock of a load. For that reason every order is paired with every size, both with fixed patterns and with random data, and each byte position is compared.

// File: rtl/bol_pkg.sv
package bol_pkg;

    typedef enum logic [1:0] {
        ORD_HIGH_FIRST = 2'd0,
        ORD_LOW_FIRST  = 2'd1,
        ORD_SPLIT      = 2'd2,
        ORD_SPARE      = 2'd3
    } order_e;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_SPARE = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_XFER   = 2'd1,
        ST_TAIL   = 2'd2,
        ST_FINISH = 2'd3
    } state_e;

    // Bytes moved for a size code; the spare code behaves as a full word.
    function automatic int unsigned beats_of(size_e s, int unsigned lanes);
        unique case (s)
            SZ_BYTE: return 1;
            SZ_HALF: return 2;
            default: return lanes;
        endcase
    endfunction

endpackage

// File: rtl/bol_lane_map.sv
module bol_lane_map
    import bol_pkg::*;
#(
    parameter int LANES = 4,
    parameter int LW    = $clog2(LANES)
) (
    input  order_e        ord,
    input  size_e         sz,
    input  logic [LW-1:0] step,
    output logic [LW-1:0] lane
);

    localparam int HALVES = LANES / 2;

    logic [LW:0]   nbeats;
    logic [LW-1:0] top_lane;
    logic [LW-2:0] half_idx;
    logic [LW-2:0] half_rev;

    always_comb begin
        nbeats   = (LW+1)'(beats_of(sz, LANES));
        top_lane = LW'(nbeats - 1'b1);
        half_idx = step[LW-1:1];
        half_rev = (LW-1)'(HALVES - 1) - half_idx;
        unique case (ord)
            ORD_HIGH_FIRST: lane = top_lane - step;
            ORD_SPLIT: begin
                if (nbeats == (LW+1)'(LANES)) begin
                    lane = {half_rev, step[0]};
                end else begin
                    lane = step;
                end
            end
            default: lane = step;
        endcase
    end

endmodule

// File: rtl/bol_seq.sv
module bol_seq
    import bol_pkg::*;
#(
    parameter int LANES = 4,
    parameter int LW    = $clog2(LANES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          wr_req,
    input  size_e         sz_req,
    output logic [LW-1:0] step,
    output logic          accept,
    output logic          issue_rd,
    output logic          issue_wr,
    output logic          done
);

    state_e        state_q;
    state_e        state_d;
    logic [LW-1:0] step_q;
    logic [LW-1:0] last_q;
    logic          wr_q;
    logic          at_last;

    assign at_last = (step_q == last_q);
    assign step    = step_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Request context and beat counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= '0;
            last_q <= '0;
            wr_q   <= 1'b0;
        end else if (accept) begin
            step_q <= '0;
            last_q <= LW'(beats_of(sz_req, LANES) - 1);
            wr_q   <= wr_req;
        end else if (state_q == ST_XFER) begin
            step_q <= at_last ? '0 : step_q + 1'b1;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d  = state_q;
        accept   = 1'b0;
        issue_rd = 1'b0;
        issue_wr = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                accept = start;
                if (start) begin
                    state_d = ST_XFER;
                end
            end
            ST_XFER: begin
                issue_rd = ~wr_q;
                issue_wr = wr_q;
                if (at_last) begin
                    state_d = wr_q ? ST_FINISH : ST_TAIL;
                end
            end
            ST_TAIL: begin
                state_d = ST_FINISH;
            end
            ST_FINISH: begin
                done    = 1'b1;
                state_d = ST_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/bol_assemble.sv
module bol_assemble #(
    parameter int LANES = 4,
    parameter int LW    = $clog2(LANES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               rd_issue,
    input  logic [LW-1:0]      lane,
    input  logic [7:0]         byte_in,
    output logic [8*LANES-1:0] word
);

    logic          cap_v_q;
    logic [LW-1:0] cap_lane_q;

    // Read data arrives one clock after the address, so the lane is delayed with it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_v_q    <= 1'b0;
            cap_lane_q <= '0;
        end else begin
            cap_v_q    <= rd_issue;
            cap_lane_q <= lane;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] byte_q;
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                byte_q <= 8'h00;
            end else if (cap_v_q && (cap_lane_q == LW'(g))) begin
                byte_q <= byte_in;
            end
        end
        assign word[8*g +: 8] = byte_q;
    end

endmodule

// File: rtl/byte_order_lsu.sv
module byte_order_lsu
    import bol_pkg::*;
#(
    parameter int AW     = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wr,
    input  logic [AW-1:0]     base_addr,
    input  logic [1:0]        size,
    input  logic [1:0]        order,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              done,
    output logic [AW-1:0]     mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata
);

    localparam int LANES = DATA_W / 8;
    localparam int LW    = $clog2(LANES);

    logic [AW-1:0]     base_q;
    order_e            ord_q;
    size_e             sz_q;
    logic [DATA_W-1:0] wdata_q;
    logic [LW-1:0]     step;
    logic [LW-1:0]     lane;
    logic              accept;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            ord_q   <= ORD_HIGH_FIRST;
            sz_q    <= SZ_BYTE;
            wdata_q <= '0;
        end else if (accept) begin
            base_q  <= base_addr;
            ord_q   <= order_e'(order);
            sz_q    <= size_e'(size);
            wdata_q <= wdata;
        end
    end

    bol_seq #(.LANES(LANES), .LW(LW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .wr_req   (wr),
        .sz_req   (size_e'(size)),
        .step     (step),
        .accept   (accept),
        .issue_rd (mem_re),
        .issue_wr (mem_we),
        .done     (done)
    );

    bol_lane_map #(.LANES(LANES), .LW(LW)) u_map (
        .ord  (ord_q),
        .sz   (sz_q),
        .step (step),
        .lane (lane)
    );

    bol_assemble #(.LANES(LANES), .LW(LW)) u_asm (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .rd_issue (mem_re),
        .lane     (lane),
        .byte_in  (mem_rdata),
        .word     (rdata)
    );

    assign mem_addr  = base_q + AW'(step);
    assign mem_wdata = 8'(wdata_q >> {lane, 3'b000});

endmodule

// File: rtl/bol_chk.sv
module bol_chk #(
    parameter int AW    = 16,
    parameter int LANES = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          done,
    input logic          mem_re,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr
);

    logic       bus;
    logic [7:0] beat_cnt;

    assign bus = mem_re | mem_we;

    always_ff @(posedge clk) begin
        if (!rst_n || done) begin
            beat_cnt <= '0;
        end else if (bus) begin
            beat_cnt <= beat_cnt + 1'b1;
        end
    end

    p_bus_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we));

    p_quiet_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !bus);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus && $past(bus)) |-> (mem_addr == AW'($past(mem_addr) + 1'b1)));

    p_beat_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (beat_cnt == 8'd1 || beat_cnt == 8'd2 || beat_cnt == 8'(LANES)));

endmodule

bind byte_order_lsu bol_chk #(.AW(AW), .LANES(DATA_W / 8)) u_bol_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .done     (done),
    .mem_re   (mem_re),
    .mem_we   (mem_we),
    .mem_addr (mem_addr)
);

// File: tb/test_byte_order_lsu.sv
module test_byte_order_lsu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        wr = 1'b0;
    logic [15:0] base_addr = '0;
    logic [1:0]  size = '0;
    logic [1:0]  order = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        done;
    logic [15:0] mem_addr;
    logic        mem_re;
    logic        mem_we;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;

    logic [7:0]  mem [256];
    int          n_tests = 0;
    int          n_fail = 0;

    always #5 clk = ~clk;

    byte_order_lsu #(.AW(16), .DATA_W(32)) i_byte_order_lsu (
        .clk(clk), .rst_n(rst_n), .start(start), .wr(wr), .base_addr(base_addr),
        .size(size), .order(order), .wdata(wdata), .rdata(rdata), .done(done),
        .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Byte memory with one-clock read latency
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int nbytes(input logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction

    // Byte expected at address A+k after a store
    function automatic logic [7:0] exp_store(input logic [1:0] md, input logic [1:0] sz,
                                             input logic [31:0] w, input int k);
        logic [7:0] b [4];
        b[0] = w[7:0]; b[1] = w[15:8]; b[2] = w[23:16]; b[3] = w[31:24];
        if (sz == 2'd0) return b[0];
        if (sz == 2'd1) return (md == 2'd0) ? b[1-k] : b[k];
        if (md == 2'd0) return b[3-k];
        if (md == 2'd1) return b[k];
        case (k)
            0: return b[2];
            1: return b[3];
            2: return b[0];
            default: return b[1];
        endcase
    endfunction

    // Word expected from a load of bytes b0..b3 at A..A+3
    function automatic logic [31:0] exp_load(input logic [1:0] md, input logic [1:0] sz,
                                             input logic [7:0] b0, input logic [7:0] b1,
                                             input logic [7:0] b2, input logic [7:0] b3);
        if (sz == 2'd0) return {24'h0, b0};
        if (sz == 2'd1) return (md == 2'd0) ? {16'h0, b0, b1} : {16'h0, b1, b0};
        if (md == 2'd0) return {b0, b1, b2, b3};
        if (md == 2'd1) return {b3, b2, b1, b0};
        return {b1, b0, b3, b2};
    endfunction

    // One request; checks addresses, beat count, done timing and pulse width.
    task automatic run_op(input bit w, input logic [15:0] a, input logic [1:0] sz,
                          input logic [1:0] md, input logic [31:0] wd, input bit poke);
        int lat;
        int beat;
        int n;
        n = nbytes(sz);
        @(negedge clk);
        start = 1'b1; wr = w; base_addr = a; size = sz; order = md; wdata = wd;
        @(negedge clk);
        start = 1'b0;
        lat = 1; beat = 0;
        forever begin
            if (poke && lat == 2) begin
                start = 1'b1; wr = 1'b1; base_addr = 16'h0080; size = 2'd2;
            end else begin
                start = 1'b0;
            end
            if (mem_re || mem_we) begin
                chk(mem_addr == a + 16'(beat), "R5 address order", 32'(mem_addr), 32'(a + 16'(beat)));
                beat++;
            end
            if (done) break;
            if (lat > 40) break;
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        chk(done == 1'b1, "R8 done reached", 32'(done), 32'd1);
        chk(beat == n, "R5 beat count", 32'(beat), 32'(n));
        chk(lat == (w ? n + 1 : n + 2), "R8 done latency", 32'(lat), 32'(w ? n + 1 : n + 2));
        @(negedge clk);
        chk(done == 1'b0, "R8 done one clock", 32'(done), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [1:0]  md;
        logic [1:0]  sz;
        logic [15:0] a;
        logic [31:0] wd;
        logic [31:0] ev;
        int          n;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        void'($urandom(32'd2024));

        repeat (3) @(negedge clk);
        chk(done == 1'b0 && mem_re == 1'b0 && mem_we == 1'b0, "R1 reset outputs",
            {29'h0, done, mem_re, mem_we}, 32'h0);
        chk(rdata == 32'h0, "R1 reset rdata", rdata, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0 && mem_re == 1'b0 && mem_we == 1'b0 && rdata == 32'h0,
            "R1 after release", {done, mem_re, mem_we, 29'h0} | rdata, 32'h0);

        // R2: high-first word store
        run_op(1'b1, 16'h0010, 2'd2, 2'd0, 32'h12345678, 1'b0);
        chk({mem[16], mem[17], mem[18], mem[19]} == 32'h12345678, "R2 store order",
            {mem[16], mem[17], mem[18], mem[19]}, 32'h12345678);
        run_op(1'b0, 16'h0010, 2'd2, 2'd0, 32'h0, 1'b0);
        chk(rdata == 32'h12345678, "R2 load", rdata, 32'h12345678);

        // R3: same bytes read low-first
        run_op(1'b0, 16'h0010, 2'd2, 2'd1, 32'h0, 1'b0);
        chk(rdata == 32'h78563412, "R3 cross-order load", rdata, 32'h78563412);

        // R4: split-word store and load
        run_op(1'b1, 16'h0020, 2'd2, 2'd2, 32'h12345678, 1'b0);
        chk({mem[32], mem[33], mem[34], mem[35]} == 32'h34127856, "R4 split store",
            {mem[32], mem[33], mem[34], mem[35]}, 32'h34127856);
        run_op(1'b0, 16'h0020, 2'd2, 2'd2, 32'h0, 1'b0);
        chk(rdata == 32'h12345678, "R4 split load", rdata, 32'h12345678);

        // R6: halfword orders
        mem[48] = 8'hAB; mem[49] = 8'hCD;
        run_op(1'b0, 16'h0030, 2'd1, 2'd0, 32'h0, 1'b0);
        chk(rdata == 32'h0000ABCD, "R6 half high-first", rdata, 32'h0000ABCD);
        run_op(1'b0, 16'h0030, 2'd1, 2'd2, 32'h0, 1'b0);
        chk(rdata == 32'h0000CDAB, "R6 half split", rdata, 32'h0000CDAB);

        // R7: byte load after a full word load clears upper bits
        mem[50] = 8'hA5; mem[51] = 8'hFF; mem[52] = 8'hFF; mem[53] = 8'hFF;
        run_op(1'b0, 16'h0032, 2'd2, 2'd1, 32'h0, 1'b0);
        run_op(1'b0, 16'h0032, 2'd0, 2'd0, 32'h0, 1'b0);
        chk(rdata == 32'h000000A5, "R7 byte zero-extend", rdata, 32'h000000A5);

        // R9: start during a busy request
        for (int k = 0; k < 8; k++) mem[8'h80 + k] = 8'hEE;
        run_op(1'b1, 16'h0040, 2'd2, 2'd0, 32'hCAFEF00D, 1'b1);
        for (int c = 0; c < 6; c++) begin
            chk(!mem_re && !mem_we && !done, "R9 no late activity",
                {29'h0, mem_re, mem_we, done}, 32'h0);
            @(negedge clk);
        end
        chk({mem[8'h80], mem[8'h81], mem[8'h82], mem[8'h83]} == 32'hEEEEEEEE, "R9 poked address untouched",
            {mem[8'h80], mem[8'h81], mem[8'h82], mem[8'h83]}, 32'hEEEEEEEE);
        chk({mem[64], mem[65], mem[66], mem[67]} == 32'hCAFEF00D, "R9 original store intact",
            {mem[64], mem[65], mem[66], mem[67]}, 32'hCAFEF00D);

        // Random mix over all orders and sizes
        for (int i = 0; i < 80; i++) begin
            md = 2'($urandom_range(2, 0));
            sz = 2'($urandom_range(2, 0));
            a  = 16'($urandom_range(240, 0));
            wd = $urandom();
            n  = nbytes(sz);
            if ($urandom_range(1, 0) == 1) begin
                for (int k = 0; k < 5; k++) mem[a[7:0] + 8'(k)] = 8'hEE;
                run_op(1'b1, a, sz, md, wd, 1'b0);
                for (int k = 0; k < n; k++) begin
                    chk(mem[a[7:0] + 8'(k)] == exp_store(md, sz, wd, k), "R2/R3/R4/R6 store lane",
                        32'(mem[a[7:0] + 8'(k)]), 32'(exp_store(md, sz, wd, k)));
                end
                chk(mem[a[7:0] + 8'(n)] == 8'hEE, "R5 no byte past end",
                    32'(mem[a[7:0] + 8'(n)]), 32'hEE);
            end else begin
                for (int k = 0; k < 4; k++) mem[a[7:0] + 8'(k)] = 8'($urandom());
                ev = exp_load(md, sz, mem[a[7:0]], mem[a[7:0] + 8'd1],
                              mem[a[7:0] + 8'd2], mem[a[7:0] + 8'd3]);
                run_op(1'b0, a, sz, md, 32'h0, 1'b0);
                chk(rdata == ev, "R2/R3/R4/R6/R7 load value", rdata, ev);
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule